// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block produces the strobe timing of one programmed-I/O cycle on an IDE channel. Each cycle has three phases in a fixed order. A setup phase comes first. An active phase follows, with the read/write strobe asserted. A hold/recovery phase ends the cycle. Each phase length is a whole number of bus clocks and comes from an 8-bit timing code. The channel has two timing codes, shared by both drives. One is for data-port cycles and one is for command/control-port cycles. The request picks between them.

The active and hold fields do not count in plain binary. Each one indexes a short table whose upper entries grow in larger steps, so a single byte spans both the slowest and the fastest PIO modes. A drive may hold its ready line low to lengthen the active phase. This is honoured only when the ready enable is set. The timer takes a request only while it is idle. It latches the selected code and the ready enable at that moment and signals the end of the cycle with a one-clock done pulse.

Top module: `ide_pio_timer`

## Requirements
- R1: While reset is asserted and after it is released, with no request, busy_o, strobe_o and done_o are low.
- R2: Code bits [7:6] set the number of setup clocks before the strobe: 00→1, 01→2, 10→3, 11→4.
- R3: Code bits [2:0] set the number of strobe clocks for codes 0..7: 2, 3, 4, 5, 6, 8, 12, 16.
- R4: Code bits [5:3] set the number of hold clocks after the strobe for codes 0..7: 1, 2, 3, 4, 5, 6, 8, 12.
- R5: A request with req_cmd_i=0 uses data_code_i. A request with req_cmd_i=1 uses cmd_code_i.
- R6: done_o is high for exactly one clock, the final hold clock. busy_o is low on the next clock.
- R7: A request is accepted only while busy_o is low. A request raised during a cycle leaves that cycle's timing unchanged.
- R8: The selected code and iordy_en_i are captured when the request is accepted. Later changes to them do not alter the running cycle.
- R9: With the ready enable captured high, iordy_i low at the last strobe clock keeps the strobe asserted. The hold phase starts on the first edge at which iordy_i is high.
- R10: With the ready enable captured low, iordy_i has no effect on the strobe length.
- R11: A request held high continuously starts the next cycle after exactly one idle clock.
- R12: Asserting rst_n low during a cycle drops busy_o and strobe_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, taken when idle |
| req_cmd_i | input | 1 | 1 = command/control timing, 0 = data timing |
| data_code_i | input | 8 | Timing code for data-port cycles |
| cmd_code_i | input | 8 | Timing code for command/control cycles |
| iordy_en_i | input | 1 | Enables stretching by the ready line |
| iordy_i | input | 1 | Drive ready line |
| strobe_o | output | 1 | Read/write strobe, high in the active phase |
| busy_o | output | 1 | High from acceptance until the cycle ends |
| done_o | output | 1 | One-clock pulse on the final hold clock |

## Verification
The edge that accepts a request moves the timer into setup. One clock later busy_o is visible and the first setup clock is under way. The first strobe clock follows after the setup count, the first hold clock after the strobe count, and done_o appears on the last busy clock. The bench samples every output on the falling edge and counts consecutive samples per phase, which gives the three lengths directly, and compares them with values derived from the code fields. Ready release, mid-cycle requests and code changes are all driven on falling edges. Their effect is judged by the phase counts of that same cycle.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/pio_code_decode.sv
// Turns a timing byte into three phase lengths, each given as clocks minus one.
module pio_code_decode
  import pio_timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CW-1:0]     setup_m1_o,
  output logic [CW-1:0]     active_m1_o,
  output logic [CW-1:0]     hold_m1_o
);
  logic [2:0] act_f;
  logic [2:0] hld_f;

  assign act_f = code_i[2:0];
  assign hld_f = code_i[5:3];

  always_comb begin
    setup_m1_o = CW'(code_i[7:6]);
  end

  // Strobe length: linear 2..6, then 8, 12, 16
  always_comb begin
    case (act_f)
      3'd5:    active_m1_o = CW'(7);
      3'd6:    active_m1_o = CW'(11);
      3'd7:    active_m1_o = CW'(15);
      default: active_m1_o = CW'(act_f) + CW'(1);
    endcase
  end

  // Recovery length: linear 1..6, then 8, 12
  always_comb begin
    case (hld_f)
      3'd6:    hold_m1_o = CW'(7);
      3'd7:    hold_m1_o = CW'(11);
      default: hold_m1_o = CW'(hld_f);
    endcase
  end
endmodule

// File: rtl/pio_phase_ctrl.sv
// Phase sequencer: idle -> setup -> active (stretchable) -> hold -> idle.
module pio_phase_ctrl
  import pio_timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] setup_m1_i,
  input  logic [CW-1:0] active_m1_i,
  input  logic [CW-1:0] hold_m1_i,
  input  logic          stretch_i,
  output logic          strobe_o,
  output logic          busy_o,
  output logic          done_o
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_clk;
  logic          upd_en;

  assign last_clk = (cnt_q == '0);
  assign upd_en   = start_i || (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SETUP;
          cnt_d   = setup_m1_i;
        end
      end
      PH_SETUP: begin
        if (last_clk) begin
          phase_d = PH_ACTIVE;
          cnt_d   = active_m1_i;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_ACTIVE: begin
        if (!last_clk) begin
          cnt_d = cnt_q - CW'(1);
        end else if (!stretch_i) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_m1_i;
        end
      end
      PH_HOLD: begin
        if (last_clk) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - CW'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign strobe_o = (phase_q == PH_ACTIVE);
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = (phase_q == PH_HOLD) && last_clk;

  p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (phase_q == PH_IDLE));

  p_strobe_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> ($past(phase_q) == PH_SETUP));

  p_hold_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> (phase_q == PH_HOLD));

  p_ready_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && last_clk && stretch_i) |=> strobe_o);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import pio_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_cmd_i,
  input  logic [CODE_W-1:0] data_code_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              iordy_en_i,
  input  logic              iordy_i,
  output logic              strobe_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_live;
  logic [CODE_W-1:0] code_use;
  logic              rdy_en_q;
  logic              accept;
  logic [CNT_W-1:0]  setup_m1, active_m1, hold_m1;

  // Reset asserts at once and is released two clocks later, on an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign accept    = req_i && !busy_o;
  assign code_live = req_cmd_i ? cmd_code_i : data_code_i;
  // Decode the live code at acceptance and the held code after it
  assign code_use  = busy_o ? code_q : code_live;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_q   <= '0;
      rdy_en_q <= 1'b0;
    end else if (accept) begin
      code_q   <= code_live;
      rdy_en_q <= iordy_en_i;
    end
  end

  pio_code_decode #(.CW(CNT_W)) u_decode (
    .code_i      (code_use),
    .setup_m1_o  (setup_m1),
    .active_m1_o (active_m1),
    .hold_m1_o   (hold_m1)
  );

  pio_phase_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (accept),
    .setup_m1_i  (setup_m1),
    .active_m1_i (active_m1),
    .hold_m1_i   (hold_m1),
    .stretch_i   (rdy_en_q && !iordy_i),
    .strobe_o    (strobe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  p_accept_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && !busy_o) |=> busy_o);

  p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |=> (!busy_o || ($stable(code_q) && $stable(rdy_en_q))));

  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!busy_o && !strobe_o && !done_o));
endmodule

// File: tb/ide_pio_timer_bench.sv
module ide_pio_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {code, setup clocks, strobe clocks, hold clocks}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'd1, 8'd2,  8'd1},
    {8'h09, 8'd1, 8'd3,  8'd2},
    {8'hF5, 8'd4, 8'd8,  8'd8},
    {8'hDE, 8'd4, 8'd12, 8'd4},
    {8'hFF, 8'd4, 8'd16, 8'd12},
    {8'h7B, 8'd2, 8'd5,  8'd12},
    {8'hA6, 8'd3, 8'd12, 8'd5},
    {8'h94, 8'd3, 8'd6,  8'd3},
    {8'h2F, 8'd1, 8'd16, 8'd6},
    {8'h70, 8'd2, 8'd2,  8'd8}
  };

  logic clk = 1'b0;
  logic rst_n, req, req_cmd, iordy_en, iordy;
  logic [7:0] dcode, ccode;
  logic strobe, busy, done;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_pio_timer u_ide_pio_timer (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_cmd_i(req_cmd),
    .data_code_i(dcode), .cmd_code_i(ccode), .iordy_en_i(iordy_en),
    .iordy_i(iordy), .strobe_o(strobe), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Raise a request on a falling edge; the next falling edge is the first busy sample
  task automatic start(input bit sel, input logic [7:0] d, input logic [7:0] c,
                       input bit ren, input bit keep);
    @(negedge clk);
    req_cmd = sel; dcode = d; ccode = c; iordy_en = ren; req = 1'b1;
    @(negedge clk);
    if (!keep) req = 1'b0;
  endtask

  // mode: 0 plain, 1 release ready after strobe count reaches rel, 2 disturb inputs
  task automatic measure(input int mode, input int rel, input bit keep,
                         output int s, output int a, output int h, output int dcnt,
                         output bit dlast);
    s = 0; a = 0; h = 0; dcnt = 0; dlast = 0;
    while (busy) begin
      if (strobe) a++;
      else if (a == 0) s++;
      else h++;
      dlast = done;
      if (done) dcnt++;
      if (mode == 1 && strobe && a == rel) iordy = 1'b1;
      if (mode == 2 && strobe && a == 1) begin
        req = 1'b1; dcode = 8'hFF; ccode = 8'hFF; iordy_en = 1'b1; req_cmd = ~req_cmd;
      end
      @(negedge clk);
    end
    if (!keep) req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, a, h, dc;
    bit dl;
    rst_n = 1'b0; req = 1'b0; req_cmd = 1'b0; dcode = 8'h00; ccode = 8'h00;
    iordy_en = 1'b0; iordy = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 strobe in reset", strobe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);

    // Table walk; the unused port carries a different code (R5)
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] cd;
      bit sel;
      cd = VEC[i][31:24];
      sel = i[0];
      start(sel, sel ? ~cd : cd, sel ? cd : ~cd, 1'b0, 1'b0);
      measure(0, 0, 1'b0, s, a, h, dc, dl);
      check($sformatf("R2 R5 setup code %0h", cd), s, int'(VEC[i][23:16]));
      check($sformatf("R3 R5 strobe code %0h", cd), a, int'(VEC[i][15:8]));
      check($sformatf("R4 R5 hold code %0h", cd), h, int'(VEC[i][7:0]));
      check($sformatf("R6 done count code %0h", cd), dc, 1);
      check($sformatf("R6 done on last clock code %0h", cd), int'(dl), 1);
    end

    // R9: ready low past the strobe length, released after 8 strobe samples
    iordy = 1'b0;
    start(1'b0, 8'h09, 8'hFF, 1'b1, 1'b0);
    measure(1, 8, 1'b0, s, a, h, dc, dl);
    check("R9 stretched strobe", a, 8);
    check("R9 hold after release", h, 2);

    // R10: ready low but ignored
    iordy = 1'b0;
    start(1'b0, 8'h09, 8'hFF, 1'b0, 1'b0);
    measure(0, 0, 1'b0, s, a, h, dc, dl);
    check("R10 strobe with ready ignored", a, 3);
    iordy = 1'b1;

    // R7 R8: mid-cycle request plus changed codes and enable, with ready low
    start(1'b0, 8'h94, 8'h00, 1'b0, 1'b0);
    iordy = 1'b0;
    measure(2, 0, 1'b0, s, a, h, dc, dl);
    iordy = 1'b1;
    check("R7 R8 setup unchanged", s, 3);
    check("R7 R8 strobe unchanged", a, 6);
    check("R7 R8 hold unchanged", h, 3);
    check("R7 idle after cycle", busy, 0);
    @(negedge clk);
    check("R7 request during cycle not queued", busy, 0);

    // R11: request held high, two cycles back to back
    start(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    measure(0, 0, 1'b1, s, a, h, dc, dl);
    check("R11 first cycle strobe", a, 2);
    check("R11 one idle sample", busy, 0);
    @(negedge clk);
    check("R11 restart after one idle clock", busy, 1);
    req = 1'b0;
    measure(0, 0, 1'b0, s, a, h, dc, dl);
    check("R11 second cycle setup", s, 1);
    check("R11 second cycle hold", h, 1);

    // R12: reset in the middle of the strobe phase
    start(1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    check("R12 strobe before reset", strobe, 1);
    #1 rst_n = 1'b0;
    #1;
    check("R12 strobe drops in reset", strobe, 0);
    check("R12 busy drops in reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset release", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule